// File: doc/BRIEF.md
# Delayed-LMS Weight Update Engine

This block holds the coefficient set of an N-tap adaptive FIR filter and adjusts every coefficient once per accepted sample. The correction for tap i is the step size times the current error times the input sample that belongs to that tap. The step size is a negative power of two, so scaling the error is an arithmetic right shift. The caller is the error computation stage. It supplies the error together with the tap-aligned sample vector, already delayed to match its own pipeline latency. The weight vector that comes out feeds that stage and also this block's next update.

Each tap multiplies the shifted error by its sample one 2-bit digit at a time. The multiples of the shifted error that a digit can select (zero, ±1×, ±2×, +3×) are formed once and shared by all taps. Each tap then sums its digit products with a shift-add chain, scales the result to the weight's binary point, and adds it to the stored weight with saturation.

A small controller sequences each update through three named states:
- ST_IDLE waits for a request. It moves to ST_MUL on the edge where enable and error-valid are both high, and stays in ST_IDLE otherwise.
- ST_MUL always moves to ST_ACC; the products are registered on that edge.
- ST_ACC always returns to ST_IDLE; the weights are written on that edge.

Top module: `dlms_wupd`

## Requirements
- R1: During and after reset all weights read zero and `upd_done` is low.
- R2: A request is accepted only on a rising edge where the block is idle and both `upd_en` and `err_vld` are high. The error and the whole sample vector are captured on that same edge.
- R3: The scaled error is `err` shifted right arithmetically by `MU_SH` bits (rounding toward minus infinity). With the defaults, an error of -1 gives -1.
- R4: Each tap forms the exact signed product of the scaled error and its own two's-complement sample. It then shifts that product right arithmetically by `FRAC_SH` bits to form the weight correction.
- R5: The corrected weights appear on `w_vec` two edges after the accepting edge. `upd_done` is high for exactly that one cycle.
- R6: A weight that would exceed the largest positive weight is held at that value, and one that would fall below the most negative weight is held there. A weight never wraps.
- R7: A request raised while an update is in flight, or with `err_vld` low, has no effect on `w_vec` or `upd_done`.
- R8: Tap i uses sample field `x_vec[i*XW +: XW]` and drives weight field `w_vec[i*WW +: WW]`. Weights persist between updates, so successive updates accumulate.
- R9: The sample is decomposed into 2-bit digits. All digits are unsigned except the most significant one, which is signed (-2..1). This gives correct products for the extreme samples -128 and 127 and for -1.
- R10: Driven as the update half of a closed loop identifying a fixed 4-tap system, the error settles below 64 in magnitude within 3000 updates. Each weight then lies within 200 of the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Update enable |
| err_vld | input | 1 | The error on `err` is valid |
| err | input | EW | Signed error of the current sample |
| x_vec | input | NTAP*XW | Delayed samples, one signed field per tap |
| w_vec | output | NTAP*WW | Current weights, one signed field per tap |
| upd_done | output | 1 | One-cycle pulse when new weights appear |

## Verification
The bench drives the extreme samples -128 and 127 and negative errors that round down. A design that treated the top digit as unsigned, or rounded the shift toward zero, would then be off by whole multiples or by one LSB. It pushes weights into both rails; a wrapping adder would flip the sign of a weight that should stay pinned. It holds a request across the busy cycle and raises enable without error-valid; a controller that reloads in ST_MUL would apply a second correction or corrupt the captured error. Finally, a closed identification loop shows that corrections with the wrong sign, the wrong tap or a bad scale prevent convergence.

// File: rtl/dlms_pkg.sv
package dlms_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_ACC  = 2'd2
    } upd_state_t;

endpackage

// File: rtl/dlms_ctrl.sv
module dlms_ctrl
    import dlms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_en,
    input  logic req_vld,
    output logic load,
    output logic mul_en,
    output logic commit,
    output logic done
);

    upd_state_t st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_en && req_vld) st_d = ST_MUL;
            ST_MUL:  st_d = ST_ACC;
            ST_ACC:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load   = 1'b0;
        mul_en = 1'b0;
        commit = 1'b0;
        unique case (st_q)
            ST_IDLE: load   = req_en && req_vld;
            ST_MUL:  mul_en = 1'b1;
            ST_ACC:  commit = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done <= 1'b0;
        else        done <= commit;
    end

    // R5
    acc_follows_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_MUL |=> st_q == ST_ACC);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !(req_en && req_vld)) |=> st_q == ST_IDLE);

endmodule

// File: rtl/dlms_err_mult.sv
module dlms_err_mult #(
    parameter int EW    = 12,
    parameter int MU_SH = 3,
    localparam int MW   = EW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [EW-1:0]        err,
    output logic signed [MW-1:0] m1,
    output logic signed [MW-1:0] m2,
    output logic signed [MW-1:0] m3,
    output logic signed [MW-1:0] n1,
    output logic signed [MW-1:0] n2
);

    logic signed [EW-1:0] me_q;

    // step size as arithmetic shift, captured with the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    me_q <= '0;
        else if (load) me_q <= $signed(err) >>> MU_SH;
    end

    // digit multiples shared by every tap
    always_comb begin
        m1 = MW'(me_q);
        m2 = MW'(me_q) <<< 1;
        m3 = m1 + m2;
        n1 = -m1;
        n2 = -m2;
    end

    // R3
    shift_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> me_q[EW-1] == $past(err[EW-1]));

endmodule

// File: rtl/dlms_tap.sv
module dlms_tap #(
    parameter int XW      = 8,
    parameter int MW      = 14,
    parameter int WW      = 16,
    parameter int FRAC_SH = 7,
    localparam int ND     = XW / 2,
    localparam int PW     = MW - 2 + XW,
    localparam int SW     = ((PW > WW) ? PW : WW) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 mul_en,
    input  logic                 commit,
    input  logic [XW-1:0]        x_in,
    input  logic signed [MW-1:0] m1,
    input  logic signed [MW-1:0] m2,
    input  logic signed [MW-1:0] m3,
    input  logic signed [MW-1:0] n1,
    input  logic signed [MW-1:0] n2,
    output logic [WW-1:0]        w
);

    localparam logic signed [SW-1:0] WMAX = {{(SW-WW+1){1'b0}}, {(WW-1){1'b1}}};
    localparam logic signed [SW-1:0] WMIN = {{(SW-WW+1){1'b1}}, {(WW-1){1'b0}}};

    logic [XW-1:0]        x_q;
    logic signed [PW-1:0] prod_q;
    logic signed [PW-1:0] prod;
    logic signed [WW-1:0] w_q;
    logic signed [MW-1:0] pp [ND];

    // digit decode and multiple select
    for (genvar j = 0; j < ND; j++) begin : g_dig
        if (j == ND - 1) begin : g_top
            always_comb begin
                unique case (x_q[2*j+1 -: 2])
                    2'b00: pp[j] = '0;
                    2'b01: pp[j] = m1;
                    2'b10: pp[j] = n2;
                    default: pp[j] = n1;
                endcase
            end
        end else begin : g_low
            always_comb begin
                unique case (x_q[2*j+1 -: 2])
                    2'b00: pp[j] = '0;
                    2'b01: pp[j] = m1;
                    2'b10: pp[j] = m2;
                    default: pp[j] = m3;
                endcase
            end
        end
    end

    // shift-add of digit products
    always_comb begin
        prod = '0;
        for (int j = 0; j < ND; j++) begin
            prod = prod + (PW'(pp[j]) <<< (2 * j));
        end
    end

    logic signed [SW-1:0] delta, sum;
    always_comb begin
        delta = SW'(prod_q >>> FRAC_SH);
        sum   = SW'(w_q) + delta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            prod_q <= '0;
            w_q    <= '0;
        end else begin
            if (load)   x_q    <= x_in;
            if (mul_en) prod_q <= prod;
            if (commit) begin
                if (sum > WMAX)      w_q <= WMAX[WW-1:0];
                else if (sum < WMIN) w_q <= WMIN[WW-1:0];
                else                 w_q <= sum[WW-1:0];
            end
        end
    end

    assign w = w_q;

    // R6
    no_wrap_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !w_q[WW-1] && !prod_q[PW-1]) |=> !w_q[WW-1]);

    // R6
    no_wrap_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && w_q[WW-1] && prod_q[PW-1]) |=> w_q[WW-1]);

    // R4
    zero_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_en && x_q == '0) |=> prod_q == '0);

endmodule

// File: rtl/dlms_wupd.sv
module dlms_wupd #(
    parameter int NTAP    = 4,
    parameter int XW      = 8,
    parameter int EW      = 12,
    parameter int WW      = 16,
    parameter int MU_SH   = 3,
    parameter int FRAC_SH = XW - 1,
    localparam int MW     = EW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic               err_vld,
    input  logic [EW-1:0]      err,
    input  logic [NTAP*XW-1:0] x_vec,
    output logic [NTAP*WW-1:0] w_vec,
    output logic               upd_done
);

    logic load, mul_en, commit;
    logic signed [MW-1:0] m1, m2, m3, n1, n2;

    dlms_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_en  (upd_en),
        .req_vld (err_vld),
        .load    (load),
        .mul_en  (mul_en),
        .commit  (commit),
        .done    (upd_done)
    );

    dlms_err_mult #(.EW(EW), .MU_SH(MU_SH)) u_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .err   (err),
        .m1    (m1),
        .m2    (m2),
        .m3    (m3),
        .n1    (n1),
        .n2    (n2)
    );

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        dlms_tap #(.XW(XW), .MW(MW), .WW(WW), .FRAC_SH(FRAC_SH)) u_tap (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .mul_en (mul_en),
            .commit (commit),
            .x_in   (x_vec[i*XW +: XW]),
            .m1     (m1),
            .m2     (m2),
            .m3     (m3),
            .n1     (n1),
            .n2     (n2),
            .w      (w_vec[i*WW +: WW])
        );
    end

    // R7
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(w_vec));

    // R5
    done_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> upd_done);

endmodule

// File: tb/sim_dlms_wupd.sv
module sim_dlms_wupd;

    localparam int NTAP = 4, XW = 8, EW = 12, WW = 16, MU_SH = 3, FRAC_SH = 7;
    localparam int WMAXI = 32767, WMINI = -32768;

    logic clk = 1'b0, rst_n = 1'b0, upd_en = 1'b0, err_vld = 1'b0;
    logic [EW-1:0] err = '0;
    logic [NTAP*XW-1:0] x_vec = '0;
    logic [NTAP*WW-1:0] w_vec;
    logic upd_done;

    int nchk = 0, nerr = 0;
    int mw [NTAP];
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dlms_wupd u0 (.clk(clk), .rst_n(rst_n), .upd_en(upd_en), .err_vld(err_vld),
                  .err(err), .x_vec(x_vec), .w_vec(w_vec), .upd_done(upd_done));

    function automatic int wget(int i);
        return int'($signed(w_vec[i*WW +: WW]));
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        for (int i = 0; i < NTAP; i++) chk(wget(i) == mw[i], req, wget(i), mw[i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_en = 1'b0; err_vld = 1'b0;
        @(negedge clk);
        // R1
        chk(upd_done == 1'b0, "R1 done", int'(upd_done), 0);
        for (int i = 0; i < NTAP; i++) begin
            mw[i] = 0;
            chk(wget(i) == 0, "R1 weight", wget(i), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // model of one update (R3, R4, R6)
    task automatic model_upd(int e, int xs [NTAP]);
        int me, p, s;
        me = e >>> MU_SH;
        for (int i = 0; i < NTAP; i++) begin
            p = me * xs[i];
            s = mw[i] + (p >>> FRAC_SH);
            if (s > WMAXI) s = WMAXI;
            if (s < WMINI) s = WMINI;
            mw[i] = s;
        end
    endtask

    task automatic do_update(int e, int xs [NTAP], string req);
        @(negedge clk);
        upd_en = 1'b1; err_vld = 1'b1; err = EW'(e);
        for (int i = 0; i < NTAP; i++) x_vec[i*XW +: XW] = XW'(xs[i]);
        @(posedge clk);
        @(negedge clk);
        upd_en = 1'b0; err_vld = 1'b0;
        chk(upd_done == 1'b0, {req, " R5 early done"}, int'(upd_done), 0);
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        model_upd(e, xs);
        // R5
        chk(upd_done == 1'b1, {req, " R5 done"}, int'(upd_done), 1);
        chk_all(req);
    endtask

    task automatic t_patterns();
        int xs [NTAP];
        do_reset();
        // R4 R8 basic
        xs = '{64, 0, -64, 1};
        do_update(1000, xs, "R4 basic");
        // R5 done pulse width
        @(negedge clk);
        chk(upd_done == 1'b0, "R5 single pulse", int'(upd_done), 1'b0);
        // R9 extreme samples
        xs = '{-128, 127, -1, 85};
        do_update(1234, xs, "R9 extremes");
        // R3 negative error, floor rounding
        xs = '{127, -128, 3, -3};
        do_update(-1, xs, "R3 minus one");
        do_update(-2048, xs, "R3 min error");
        // R8 accumulation
        xs = '{-86, 42, 100, -100};
        do_update(777, xs, "R8 accumulate");
        do_update(777, xs, "R8 accumulate2");
    endtask

    task automatic t_ignore();
        int keep [NTAP];
        keep = mw;
        // R7 enable without valid, then valid without enable
        @(negedge clk);
        upd_en = 1'b1; err_vld = 1'b0; err = EW'(2000);
        x_vec = {NTAP{8'sd100}};
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(upd_done == 1'b0, "R7 no valid done", int'(upd_done), 0);
        end
        upd_en = 1'b0; err_vld = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(upd_done == 1'b0, "R2 no enable done", int'(upd_done), 0);
        end
        err_vld = 1'b0;
        mw = keep;
        chk_all("R7 weights kept");
    endtask

    task automatic t_busy();
        int xs [NTAP];
        xs = '{50, -50, 120, -7};
        @(negedge clk);
        upd_en = 1'b1; err_vld = 1'b1; err = EW'(900);
        for (int i = 0; i < NTAP; i++) x_vec[i*XW +: XW] = XW'(xs[i]);
        @(posedge clk);
        @(negedge clk);
        // second request while busy, different values
        err = EW'(-1500);
        x_vec = {NTAP{8'sd127}};
        @(posedge clk);
        @(negedge clk);
        upd_en = 1'b0; err_vld = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_upd(900, xs);
        chk(upd_done == 1'b1, "R2 busy first done", int'(upd_done), 1);
        chk_all("R2 captured at accept");
        repeat (4) begin
            @(negedge clk);
            chk(upd_done == 1'b0, "R7 busy request dropped", int'(upd_done), 0);
        end
        chk_all("R7 busy no second update");
    endtask

    task automatic t_sat();
        int xs [NTAP];
        do_reset();
        xs = '{127, 127, -128, -128};
        for (int k = 0; k < 135; k++) do_update(2047, xs, "R6 ramp");
        // R6 rails
        chk(wget(0) == WMAXI, "R6 top rail", wget(0), WMAXI);
        chk(wget(2) == WMINI, "R6 bottom rail", wget(2), WMINI);
        xs = '{-128, 0, 127, 0};
        do_update(-2048, xs, "R6 push again");
        chk(wget(0) == WMAXI, "R6 stays top", wget(0), WMAXI);
        chk(wget(2) == WMINI, "R6 stays bottom", wget(2), WMINI);
    endtask

    task automatic t_sysid();
        int h [NTAP];
        int xs [NTAP];
        int d, y, e, run, hit;
        logic [15:0] lf;
        h = '{3000, -2000, 1000, 500};
        xs = '{0, 0, 0, 0};
        lf = 16'hACE1;
        run = 0; hit = -1;
        do_reset();
        for (int it = 0; it < 3000 && hit < 0; it++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            for (int i = NTAP - 1; i > 0; i--) xs[i] = xs[i-1];
            xs[0] = int'($signed(lf[7:0]));
            d = 0; y = 0;
            for (int i = 0; i < NTAP; i++) begin
                d += h[i] * xs[i];
                y += wget(i) * xs[i];
            end
            e = (d >>> FRAC_SH) - (y >>> FRAC_SH);
            if (e > 2047) e = 2047;
            if (e < -2048) e = -2048;
            if (e < 64 && e > -64) run++; else run = 0;
            if (run >= 8) hit = it;
            do_update(e, xs, "R10 loop");
        end
        // R10
        chk(hit >= 0, "R10 converged", hit, 1);
        for (int i = 0; i < NTAP; i++)
            chk(wget(i) - h[i] < 200 && h[i] - wget(i) < 200, "R10 weight near target", wget(i), h[i]);
    endtask

    initial begin
        t_patterns();
        t_ignore();
        t_busy();
        t_sat();
        t_sysid();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule